// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block records which cache lines a processor port currently has in flight. Each new request is classified by its kind code as read-class or write-class. If admitted, it takes a slot in the matching table: a small fully associative store keyed by line address. The line address is the request address with its low offset bits dropped. The block answers each request in the same cycle with a status code. The request is either issued, refused because the total in flight has reached the configured cap, or refused as aliased because its line already has a conflicting request in flight. Completion responses name a line and a table, and they free the matching slot.

An age watchdog runs whenever anything is in flight. It samples all live entries once every THRESH cycles. It raises a sticky error if any entry has been outstanding for THRESH cycles or more. Four counters record how often each kind of alias refusal has happened.

The request side is a valid/ready port. `req_ready` is low during reset and stays high from the first clock edge after reset. A request is consumed on every cycle where `req_valid` and `req_ready` are both high, whatever status it gets. A refused request is therefore dropped, and the requester retries it later. `req_status` is combinational and is valid in that same cycle. The completion port has no back-pressure: each cycle with `cmp_valid` high is one completion.

Top module: `line_inflight_tracker`

## Requirements
- R1: When the number in flight equals MAX_OUT at the start of a cycle, a request gets status 1 (full) even if it would also alias. A completion in the same cycle does not make room for it.
- R2: Kind codes 0 and 1 are read-class. Every other code (2 to 15) is write-class. An admitted request gets status 0 (issued) and enters the table of its class.
- R3: A write-class request is refused with status 2 if its line is in the read table. Otherwise it is refused with status 2 if its line is already in the write table.
- R4: A read-class request is refused with status 2 if its line is in the write table. Otherwise it is refused with status 2 if its line is already in the read table.
- R5: Four counters each rise by one per refusal of their own case and otherwise hold their value. The cases are: write behind read, write behind write, read behind write, and read behind read.
- R6: `out_cnt` equals the number of live entries in both tables together. It never exceeds MAX_OUT and is visible one cycle after each change.
- R7: A completion whose line is live in the selected table (`cmp_is_write` 1 selects the write table) frees that entry. The line can be requested again from the next cycle.
- R8: A completion that matches no live entry in the selected table leaves all state unchanged. It raises `cmp_err` for exactly the following cycle.
- R9: The watchdog takes its first sample THRESH cycles after a request is admitted while the watchdog is idle. `wdog_err` rises at exactly the THRESH-th clock edge after that admission if the entry is still live, and then stays high until reset.
- R10: After a sample, the next one follows THRESH cycles later while anything is in flight. Otherwise the watchdog goes idle. An entry that is younger than THRESH at a sample is not flagged until a later sample.
- R11: Status codes are 0 issued, 1 full, 2 aliased. `req_ready` is 0 in reset and 1 from the first edge after reset.
- R12: Reset empties both tables and clears every counter, `cmp_err` and `wdog_err`.
- R13: Two addresses that differ only in their low OFF_W bits are the same line and alias one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_kind | input | 4 | Request kind code (0 load, 1 fetch, 2 and up write-class) |
| req_status | output | 2 | 0 issued, 1 full, 2 aliased |
| cmp_valid | input | 1 | Completion present |
| cmp_line | input | ADDR_W-OFF_W | Line address being completed |
| cmp_is_write | input | 1 | 1 selects the write table |
| cmp_err | output | 1 | Completion matched nothing (one cycle later) |
| wdog_err | output | 1 | Sticky age error |
| out_cnt | output | clog2(MAX_OUT+1) | Entries in flight |
| n_st_on_ld | output | CNT_W | Write refused behind read |
| n_st_on_st | output | CNT_W | Write refused behind write |
| n_ld_on_st | output | CNT_W | Read refused behind write |
| n_ld_on_ld | output | CNT_W | Read refused behind read |

## Verification
Some faults leave the table contents wrong: a slot never freed, a stale valid bit, or an entry filed in the wrong table. These show at the ports on the very next request to that line, which gets the wrong status, and in `out_cnt` one cycle after the error. A wrong stamp or a wrong timer phase shows only through `wdog_err`, so the bench compares its exact rising edge against a reference. It uses one case where the error rises at the first sample and one where it must wait for the second. A behavioural model with associative maps predicts status, count, counters and both error flags on every clock, across directed cases and a random mix on a few colliding lines.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int KIND_W = 4;

  typedef enum logic [1:0] {
    ST_ISSUED = 2'd0,
    ST_FULL   = 2'd1,
    ST_ALIAS  = 2'd2
  } stat_e;

  // codes 0 and 1 read, all others write-class
  function automatic logic is_wr_class(input logic [KIND_W-1:0] k);
    return k > 4'd1;
  endfunction
endpackage

// File: rtl/lt_line_cam.sv
module lt_line_cam #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 12,
  parameter int TS_W    = 8,
  parameter int THRESH  = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LINE_W-1:0]              look_line,
  output logic                           look_hit,
  input  logic                           ins_en,
  input  logic [LINE_W-1:0]              ins_line,
  input  logic                           del_en,
  input  logic [LINE_W-1:0]              del_line,
  output logic                           del_hit,
  input  logic [TS_W-1:0]                now,
  output logic                           old_any,
  output logic [$clog2(ENTRIES+1)-1:0]   count
);
  localparam int CW = $clog2(ENTRIES+1);

  logic [ENTRIES-1:0] vld, look_m, del_m, free_oh, old_m;

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic              v_q;
      logic [LINE_W-1:0] t_q;
      logic [TS_W-1:0]   s_q;
      logic [TS_W-1:0]   age;

      assign vld[i]    = v_q;
      assign look_m[i] = v_q && (t_q == look_line);
      assign del_m[i]  = v_q && (t_q == del_line);
      assign age       = now - s_q;
      assign old_m[i]  = v_q && (age >= TS_W'(THRESH));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          t_q <= '0;
          s_q <= '0;
        end else if (del_en && del_m[i]) begin
          v_q <= 1'b0;
        end else if (ins_en && free_oh[i]) begin
          v_q <= 1'b1;
          t_q <= ins_line;
          s_q <= now;
        end
      end
    end
  endgenerate

  // lowest free slot
  always_comb begin : p_free
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      free_oh[i] = !vld[i] && !seen;
      seen       = seen | !vld[i];
    end
  end

  assign look_hit = |look_m;
  assign del_hit  = |del_m;
  assign old_any  = |old_m;
  assign count    = CW'($countones(vld));
endmodule

// File: rtl/lt_age_watch.sv
module lt_age_watch #(
  parameter int THRESH = 64,
  parameter int TS_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            busy_next,
  input  logic            old_any,
  output logic [TS_W-1:0] now,
  output logic            err
);
  localparam int TMR_W = $clog2(THRESH+1);

  logic             run_q, err_q, fire;
  logic [TMR_W-1:0] tmr_q;
  logic [TS_W-1:0]  now_q;

  assign fire = run_q && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tmr_q <= '0;
      now_q <= '0;
      err_q <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      if (fire) begin
        if (old_any) err_q <= 1'b1;
        if (busy_next) tmr_q <= TMR_W'(THRESH-1);
        else           run_q <= 1'b0;
      end else if (run_q) begin
        tmr_q <= tmr_q - 1'b1;
      end else if (start) begin
        run_q <= 1'b1;
        tmr_q <= TMR_W'(THRESH-1);
      end
    end
  end

  assign now = now_q;
  assign err = err_q;
endmodule

// File: rtl/line_inflight_tracker.sv
module line_inflight_tracker #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int MAX_OUT = 4,
  parameter int THRESH  = 64,
  parameter int CNT_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [3:0]                    req_kind,
  output logic [1:0]                    req_status,
  input  logic                          cmp_valid,
  input  logic [ADDR_W-OFF_W-1:0]       cmp_line,
  input  logic                          cmp_is_write,
  output logic                          cmp_err,
  output logic                          wdog_err,
  output logic [$clog2(MAX_OUT+1)-1:0]  out_cnt,
  output logic [CNT_W-1:0]              n_st_on_ld,
  output logic [CNT_W-1:0]              n_st_on_st,
  output logic [CNT_W-1:0]              n_ld_on_st,
  output logic [CNT_W-1:0]              n_ld_on_ld
);
  import lt_pkg::*;

  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TS_W   = $clog2(THRESH) + 2;
  localparam int CW     = $clog2(MAX_OUT+1);

  logic              ready_q, cmp_err_q, fire, wr_cls;
  logic [LINE_W-1:0] req_line;
  logic              rd_look, wr_look, rd_del, wr_del, del_ok;
  logic              rd_old, wr_old, busy_next;
  logic [CW-1:0]     rd_cnt, wr_cnt, total;
  logic [CW:0]       nxt;
  logic [TS_W-1:0]   now;
  logic              ins_rd, ins_wr, rd_ins_en, wr_ins_en;
  logic [3:0]        bump;
  stat_e             st;
  logic              unused_off;

  assign req_line   = req_addr[ADDR_W-1:OFF_W];
  assign unused_off = ^req_addr[OFF_W-1:0];
  assign fire       = req_valid && ready_q;
  assign total      = rd_cnt + wr_cnt;

  // admission decision: cap first, then cross-table, then same-table
  always_comb begin
    st     = ST_ISSUED;
    ins_rd = 1'b0;
    ins_wr = 1'b0;
    bump   = '0;
    wr_cls = is_wr_class(req_kind);
    if (total >= CW'(MAX_OUT)) begin
      st = ST_FULL;
    end else if (wr_cls) begin
      if (rd_look)      begin st = ST_ALIAS; bump[0] = 1'b1; end
      else if (wr_look) begin st = ST_ALIAS; bump[1] = 1'b1; end
      else              ins_wr = 1'b1;
    end else begin
      if (wr_look)      begin st = ST_ALIAS; bump[2] = 1'b1; end
      else if (rd_look) begin st = ST_ALIAS; bump[3] = 1'b1; end
      else              ins_rd = 1'b1;
    end
  end

  assign rd_ins_en = fire && ins_rd;
  assign wr_ins_en = fire && ins_wr;
  assign del_ok    = cmp_is_write ? wr_del : rd_del;
  assign nxt       = {1'b0, total} + {{CW{1'b0}}, (rd_ins_en | wr_ins_en)}
                   - {{CW{1'b0}}, (cmp_valid && del_ok)};
  assign busy_next = (nxt != '0);

  lt_line_cam #(.ENTRIES(MAX_OUT), .LINE_W(LINE_W), .TS_W(TS_W), .THRESH(THRESH)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(rd_look),
    .ins_en(rd_ins_en), .ins_line(req_line),
    .del_en(cmp_valid && !cmp_is_write), .del_line(cmp_line), .del_hit(rd_del),
    .now(now), .old_any(rd_old), .count(rd_cnt)
  );

  lt_line_cam #(.ENTRIES(MAX_OUT), .LINE_W(LINE_W), .TS_W(TS_W), .THRESH(THRESH)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(wr_look),
    .ins_en(wr_ins_en), .ins_line(req_line),
    .del_en(cmp_valid && cmp_is_write), .del_line(cmp_line), .del_hit(wr_del),
    .now(now), .old_any(wr_old), .count(wr_cnt)
  );

  lt_age_watch #(.THRESH(THRESH), .TS_W(TS_W)) u_wd (
    .clk(clk), .rst_n(rst_n),
    .start(rd_ins_en | wr_ins_en), .busy_next(busy_next),
    .old_any(rd_old | wr_old), .now(now), .err(wdog_err)
  );

  logic [CNT_W-1:0] ctr_q [4];
  generate
    for (genvar k = 0; k < 4; k++) begin : g_ctr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ctr_q[k] <= '0;
        else if (fire && bump[k])  ctr_q[k] <= ctr_q[k] + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      cmp_err_q <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      cmp_err_q <= cmp_valid && !del_ok;
    end
  end

  assign req_ready  = ready_q;
  assign req_status = st;
  assign cmp_err    = cmp_err_q;
  assign out_cnt    = total;
  assign n_st_on_ld = ctr_q[0];
  assign n_st_on_st = ctr_q[1];
  assign n_ld_on_st = ctr_q[2];
  assign n_ld_on_ld = ctr_q[3];
endmodule

// File: rtl/lt_tracker_chk.sv
module lt_tracker_chk #(
  parameter int MAX_OUT = 4,
  parameter int CNT_W   = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [1:0]                    req_status,
  input logic                          cmp_valid,
  input logic                          cmp_err,
  input logic                          wdog_err,
  input logic [$clog2(MAX_OUT+1)-1:0]  out_cnt,
  input logic [CNT_W-1:0]              n_st_on_ld,
  input logic [CNT_W-1:0]              n_st_on_st,
  input logic [CNT_W-1:0]              n_ld_on_st,
  input logic [CNT_W-1:0]              n_ld_on_ld
);
  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= MAX_OUT);

  assert_full_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && out_cnt == MAX_OUT) |-> req_status == 2'd1);

  assert_issue_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_status == 2'd0 && !cmp_valid)
      |=> out_cnt == $past(out_cnt) + 1);

  assert_refuse_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_status != 2'd0 && !cmp_valid) |=> $stable(out_cnt));

  assert_orphan_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && out_cnt == 0) |=> cmp_err);

  assert_wdog_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_err |=> wdog_err);

  assert_ctr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_status == 2'd2)
      |=> $stable({n_st_on_ld, n_st_on_st, n_ld_on_st, n_ld_on_ld}));

  assert_ready_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);
endmodule

bind line_inflight_tracker lt_tracker_chk #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_status(req_status), .cmp_valid(cmp_valid), .cmp_err(cmp_err),
  .wdog_err(wdog_err), .out_cnt(out_cnt), .n_st_on_ld(n_st_on_ld),
  .n_st_on_st(n_st_on_st), .n_ld_on_st(n_ld_on_st), .n_ld_on_ld(n_ld_on_ld)
);

// File: tb/sim_line_inflight_tracker.sv
`timescale 1ns/100ps
module sim_line_inflight_tracker;
  localparam int ADDR_W = 16, OFF_W = 4, MAXO = 4, THR = 64, CNT_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 0, cmp_valid = 0, cmp_is_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_kind = '0;
  logic [ADDR_W-OFF_W-1:0] cmp_line = '0;
  logic req_ready, cmp_err, wdog_err;
  logic [1:0] req_status;
  logic [2:0] out_cnt;
  logic [CNT_W-1:0] n_st_on_ld, n_st_on_st, n_ld_on_st, n_ld_on_ld;

  line_inflight_tracker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MAX_OUT(MAXO),
                          .THRESH(THR), .CNT_W(CNT_W)) u0 (.*);

  int nchk = 0, nerr = 0, ecnt = 0;
  bit done = 0;

  // reference model state
  int rd_m[int];
  int wr_m[int];
  int m_now, m_trun, m_tmr, m_err, m_cerr, m_ready;
  int m_ctr[4];

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int decide(input int kind, input int line,
                                output string tag, output int which);
    which = 0;
    if (rd_m.num() + wr_m.num() >= MAXO) begin tag = "R1 full"; return 1; end
    if (kind >= 2) begin
      if (rd_m.exists(line)) begin tag = "R3 write behind read";  which = 0; return 2; end
      if (wr_m.exists(line)) begin tag = "R3 write behind write"; which = 1; return 2; end
      tag = "R2 write issued"; return 0;
    end
    if (wr_m.exists(line)) begin tag = "R4 read behind write"; which = 2; return 2; end
    if (rd_m.exists(line)) begin tag = "R4 read behind read";  which = 3; return 2; end
    tag = "R2 read issued"; return 0;
  endfunction

  always @(posedge clk) begin
    ecnt++;
    if (!rst_n) begin
      rd_m.delete(); wr_m.delete();
      m_now = 0; m_trun = 0; m_tmr = 0; m_err = 0; m_cerr = 0; m_ready = 0;
      foreach (m_ctr[i]) m_ctr[i] = 0;
    end else begin
      int st, wh, line, cl, hit, wfire, old, cnt;
      string tg;
      line  = int'(req_addr) >> OFF_W;
      cl    = int'(cmp_line);
      st    = decide(int'(req_kind), line, tg, wh);
      wfire = (m_trun != 0) && (m_tmr == 0);
      old   = 0;
      foreach (rd_m[k]) if (m_now - rd_m[k] >= THR) old = 1;
      foreach (wr_m[k]) if (m_now - wr_m[k] >= THR) old = 1;
      hit    = cmp_is_write ? int'(wr_m.exists(cl)) : int'(rd_m.exists(cl));
      m_cerr = (cmp_valid && hit == 0) ? 1 : 0;
      if (cmp_valid && hit != 0) begin
        if (cmp_is_write) wr_m.delete(cl); else rd_m.delete(cl);
      end
      if (m_ready != 0 && req_valid) begin
        if (st == 0) begin
          if (req_kind >= 2) wr_m[line] = m_now; else rd_m[line] = m_now;
        end else if (st == 2) m_ctr[wh]++;
      end
      cnt = rd_m.num() + wr_m.num();
      if (wfire != 0) begin
        if (old != 0) m_err = 1;
        if (cnt > 0) m_tmr = THR - 1; else m_trun = 0;
      end else if (m_trun != 0) m_tmr--;
      else if (m_ready != 0 && req_valid && st == 0) begin
        m_trun = 1; m_tmr = THR - 1;
      end
      m_now++;
      m_ready = 1;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int st, wh;
      string tg;
      chk("R11 ready", int'(req_ready), m_ready);
      if (req_valid && m_ready != 0) begin
        st = decide(int'(req_kind), int'(req_addr) >> OFF_W, tg, wh);
        chk(tg, int'(req_status), st);
      end
      chk("R6 count", int'(out_cnt), rd_m.num() + wr_m.num());
      chk("R5 write behind read",  int'(n_st_on_ld), m_ctr[0]);
      chk("R5 write behind write", int'(n_st_on_st), m_ctr[1]);
      chk("R5 read behind write",  int'(n_ld_on_st), m_ctr[2]);
      chk("R5 read behind read",   int'(n_ld_on_ld), m_ctr[3]);
      chk("R8 completion error", int'(cmp_err), m_cerr);
      chk("R9 watchdog", int'(wdog_err), m_err);
    end
  end

  task automatic drv(input bit rv, input int kind, input int addr,
                     input bit cv, input int cl, input bit cw);
    @(posedge clk); #1;
    req_valid = rv; req_kind = 4'(kind); req_addr = 16'(addr);
    cmp_valid = cv; cmp_line = 12'(cl); cmp_is_write = cw;
  endtask
  task automatic idle(input int n);
    repeat (n) drv(0, 0, 0, 0, 0, 0);
  endtask
  task automatic req(input int kind, input int addr);
    drv(1, kind, addr, 0, 0, 0);
  endtask
  task automatic cmp(input int cl, input bit cw);
    drv(0, 0, 0, 1, cl, cw);
  endtask
  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0;
    idle(3);
    #1;
    chk("R12 count in reset", int'(out_cnt), 0);
    chk("R12 wdog in reset", int'(wdog_err), 0);
    chk("R12 cmp_err in reset", int'(cmp_err), 0);
    chk("R12 ready in reset", int'(req_ready), 0);
    chk("R12 counters in reset", int'(n_st_on_ld | n_st_on_st | n_ld_on_st | n_ld_on_ld), 0);
    @(posedge clk); #1; rst_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL run timeout, all requirements actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int t0;
    do_reset();
    idle(1);
    // directed admission and alias cases
    req(0, 'h0100); #1 chk("R2 load issued", int'(req_status), 0);
    req(0, 'h0104); #1 chk("R13 same line other offset", int'(req_status), 2);
    req(2, 'h0108); #1 chk("R3 store behind load", int'(req_status), 2);
    req(2, 'h0200); #1 chk("R2 store issued", int'(req_status), 0);
    req(1, 'h020C); #1 chk("R4 fetch behind store", int'(req_status), 2);
    req(9, 'h0200); #1 chk("R3 flush behind store", int'(req_status), 2);
    req(12, 'h0300); #1 chk("R2 code 12 is write class", int'(req_status), 0);
    req(5, 'h0400); #1 chk("R2 linked load issued", int'(req_status), 0);
    req(0, 'h0500); #1 chk("R1 full", int'(req_status), 1);
    req(0, 'h0100); #1 chk("R1 full before alias", int'(req_status), 1);
    idle(1); chk("R6 count at cap", int'(out_cnt), 4);
    cmp('h010, 0); idle(1); chk("R7 retire read", int'(out_cnt), 3);
    req(0, 'h0100); #1 chk("R7 line reusable", int'(req_status), 0);
    cmp('h010, 1); idle(1);
    chk("R8 wrong table flag", int'(cmp_err), 1);
    chk("R8 count unchanged", int'(out_cnt), 4);
    cmp('h020, 0); idle(1); chk("R8 read table miss", int'(cmp_err), 1);
    drv(1, 2, 'h0600, 1, 'h020, 1); #1 chk("R1 full despite same-cycle retire", int'(req_status), 1);
    idle(1); chk("R7 same-cycle retire", int'(out_cnt), 3);
    cmp('h030, 1); cmp('h040, 1); cmp('h010, 0); idle(1);
    chk("R7 all retired", int'(out_cnt), 0);
    chk("R5 write behind read",  int'(n_st_on_ld), 1);
    chk("R5 write behind write", int'(n_st_on_st), 1);
    chk("R5 read behind write",  int'(n_ld_on_st), 1);
    chk("R5 read behind read",   int'(n_ld_on_ld), 1);

    // random mix on a few colliding lines
    for (int i = 0; i < 400; i++) begin
      drv(1'($urandom_range(0, 1)), $urandom_range(0, 15),
          ($urandom_range(0, 7) << OFF_W) | $urandom_range(0, 15),
          1'($urandom_range(0, 2) == 0), $urandom_range(0, 7), 1'($urandom_range(0, 1)));
    end
    idle(2);

    // cadence: second entry only caught at the second sample
    do_reset();
    req(0, 'h0A00); idle(1); t0 = ecnt;
    idle(3); cmp('h0A0, 0); req(2, 'h0B00); idle(1);
    while (ecnt < t0 + THR) idle(1);
    chk("R10 young entry not flagged at first sample", int'(wdog_err), 0);
    while (ecnt < t0 + 2 * THR - 1) idle(1);
    chk("R10 before second sample", int'(wdog_err), 0);
    idle(1);
    chk("R10 flagged at second sample", int'(wdog_err), 1);

    // exact threshold at first sample
    do_reset();
    req(0, 'h0C00); idle(1); t0 = ecnt;
    while (ecnt < t0 + THR - 1) idle(1);
    chk("R9 one edge early", int'(wdog_err), 0);
    idle(1);
    chk("R9 raised at threshold", int'(wdog_err), 1);
    cmp('h0C0, 0); idle(3);
    chk("R9 sticky after retire", int'(wdog_err), 1);
    finish_run();
  end
endmodule